// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block takes a single pulse-width-modulated waveform and turns it into two complementary drive signals for a half-bridge. One signal drives the high-side switch and the other drives the low-side switch. Power switches turn off more slowly than they turn on. To cover that gap, the block holds back every switch-on edge by a programmable number of instruction-cycle ticks. Every switch-off edge passes through at once, so the opposite device is already off before its partner starts to conduct.

Each output has its own down-counter. A counter loads from the 7-bit delay input on the clock where its output is first requested. It counts down only on clocks where the tick enable is high. The tick is meant to pulse once per instruction cycle, which is four oscillator periods. A polarity input selects whether "active" means a high or a low level on both drive pins. The PWM source is assumed to be synchronous to the clock.

Top module: `hb_deadband`

## Requirements
- R1: While `rst` is high, both drive outputs sit at their inactive level, `~act_high`, and both channels are idle with cleared counters. The reset is synchronous.
- R2: The high-side output is requested while `pwm_in` is 1, and the low-side output is requested while `pwm_in` is 0.
- R3: With `dly_cnt` = 0, the requested output becomes active on the first clock edge that sees the new `pwm_in` level. The two outputs are then exact complements with no gap.
- R4: With `dly_cnt` = N > 0, the requested output becomes active on the clock edge carrying the N-th `tick` after the edge that saw the request start. A tick on that starting edge itself does not count.
- R5: An output goes inactive on the first clock edge that sees `pwm_in` leave its requesting level, with no delay.
- R6: If `pwm_in` leaves a channel's requesting level before that channel's count finishes, the pending activation is dropped. The output never goes active for that request.
- R7: The two outputs are never active at the same time.
- R8: `dly_cnt` is sampled only on the clock where a request starts. Changes to it while a count is running do not alter that count.
- R9: A running count advances only on clocks where `tick` is 1.
- R10: With `act_high` = 1, the active level is 1. With `act_high` = 0, the active level is 0 and the inactive level is 1, on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per instruction cycle; enables counting |
| pwm_in | input | 1 | Raw PWM: 1 requests high side, 0 requests low side |
| dly_cnt | input | 7 | Dead-band length in ticks, sampled at request start |
| act_high | input | 1 | Output polarity: 1 active-high, 0 active-low |
| drv_up | output | 1 | High-side switch drive |
| drv_dn | output | 1 | Low-side switch drive |

## Verification
Several internal faults show at the ports within a few cycles of the next PWM edge:

- A counter loaded from the wrong value, or a counter that counts on clocks without a tick, moves the switch-on edge of one output by whole tick periods.
- A channel that fails to return to idle when its request drops leaves both outputs active together on the very next clock.
- A request-edge register that misses its reset leaves one output dead after reset until `pwm_in` toggles.

Sweeping the delay over both polarities with dense and sparse ticks, plus the maximum count, exposes each of these faults on the first affected transition.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  localparam int unsigned HB_CH_NUM = 2;
  localparam int unsigned HB_CH_UP  = 0;
  localparam int unsigned HB_CH_DN  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } hb_st_e;
endpackage

// File: rtl/hb_req_edge.sv
`timescale 1ns/1ps
// Splits the PWM level into per-channel requests and flags the clock
// on which each request begins.
module hb_req_edge #(
  parameter int unsigned CH_NUM = hb_pkg::HB_CH_NUM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  output logic [CH_NUM-1:0] req,
  output logic [CH_NUM-1:0] rise
);
  logic [CH_NUM-1:0] req_q;

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_req
      if (g == hb_pkg::HB_CH_UP) begin : g_up
        assign req[g] = pwm_in;
      end else begin : g_dn
        assign req[g] = ~pwm_in;
      end
    end
  endgenerate

  // Cleared at reset so both channels see a fresh request afterwards.
  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req;
  end

  assign rise = req & ~req_q;
endmodule

// File: rtl/hb_dly_chan.sv
`timescale 1ns/1ps
// One channel: waits out the dead band before granting activation.
module hb_dly_chan
  import hb_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req,
  input  logic             rise,
  input  logic [CNT_W-1:0] dly,
  output logic             on_nxt
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  hb_st_e           st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (!req) begin
      st_nxt  = ST_IDLE;
      cnt_nxt = CNT_ZERO;
    end else if (rise) begin
      if (dly == CNT_ZERO) begin
        st_nxt  = ST_ON;
        cnt_nxt = CNT_ZERO;
      end else begin
        st_nxt  = ST_WAIT;
        cnt_nxt = dly;
      end
    end else if (st == ST_WAIT && tick) begin
      if (cnt == CNT_ONE) begin
        st_nxt  = ST_ON;
        cnt_nxt = CNT_ZERO;
      end else begin
        cnt_nxt = cnt - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= CNT_ZERO;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  assign on_nxt = (st_nxt == ST_ON);

  // R3
  zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && dly == CNT_ZERO) |=> (st == ST_ON));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && dly != CNT_ZERO) |=> (st == ST_WAIT && cnt == $past(dly)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && req && !rise && !tick) |=> (st == ST_WAIT && $stable(cnt)));
  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !req) |=> (st == ST_IDLE));
endmodule

// File: rtl/hb_out_stage.sv
`timescale 1ns/1ps
// Applies the polarity and registers the drive pins.
module hb_out_stage #(
  parameter int unsigned CH_NUM = hb_pkg::HB_CH_NUM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_high,
  input  logic [CH_NUM-1:0] on_nxt,
  output logic [CH_NUM-1:0] drv
);
  logic [CH_NUM-1:0] inv_mask;
  assign inv_mask = {CH_NUM{~act_high}};

  always_ff @(posedge clk) begin
    if (rst) drv <= inv_mask;
    else     drv <= on_nxt ^ inv_mask;
  end
endmodule

// File: rtl/hb_deadband.sv
`timescale 1ns/1ps
module hb_deadband #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] dly_cnt,
  input  logic             act_high,
  output logic             drv_up,
  output logic             drv_dn
);
  localparam int unsigned CH_NUM = hb_pkg::HB_CH_NUM;

  logic [CH_NUM-1:0] req;
  logic [CH_NUM-1:0] rise;
  logic [CH_NUM-1:0] on_nxt;
  logic [CH_NUM-1:0] drv;

  hb_req_edge #(.CH_NUM(CH_NUM)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .req    (req),
    .rise   (rise)
  );

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
      hb_dly_chan #(.CNT_W(CNT_W)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .req    (req[g]),
        .rise   (rise[g]),
        .dly    (dly_cnt),
        .on_nxt (on_nxt[g])
      );
    end
  endgenerate

  hb_out_stage #(.CH_NUM(CH_NUM)) u_out (
    .clk      (clk),
    .rst      (rst),
    .act_high (act_high),
    .on_nxt   (on_nxt),
    .drv      (drv)
  );

  assign drv_up = drv[hb_pkg::HB_CH_UP];
  assign drv_dn = drv[hb_pkg::HB_CH_DN];

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(on_nxt[hb_pkg::HB_CH_UP] && on_nxt[hb_pkg::HB_CH_DN]));
  // R5
  up_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_in |=> (drv_up == ~$past(act_high)));
  // R5
  dn_off_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_in |=> (drv_dn == ~$past(act_high)));
endmodule

// File: tb/hb_deadband_test.sv
`timescale 1ns/1ps
module hb_deadband_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       pwm_in = 1'b0;
  logic [6:0] dly_cnt = '0;
  logic       act_high = 1'b1;
  logic       drv_up, drv_dn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_deadband uut (
    .clk(clk), .rst(rst), .tick(tick), .pwm_in(pwm_in),
    .dly_cnt(dly_cnt), .act_high(act_high),
    .drv_up(drv_up), .drv_dn(drv_dn)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Drive pwm to lvl, then expect the requested output active on sample j
  // (taken after edge E+j) iff j >= d*p, with ticks on edges where j%p==0.
  task automatic phase(input logic lvl, input int d, input int p, input logic pol);
    int lim;
    lim = d * p;
    @(negedge clk);
    pwm_in   = lvl;
    dly_cnt  = 7'(d);
    act_high = pol;
    tick     = 1'b0;
    for (int j = 0; j <= lim + 2; j++) begin
      logic on_exp, tgt, oth;
      @(posedge clk);
      @(negedge clk);
      on_exp = (j >= lim);
      tgt = lvl ? drv_up : drv_dn;
      oth = lvl ? drv_dn : drv_up;
      // R4 R3 R9 R8 R2 R10: activation timing and level
      check(d == 0 ? "R3 zero delay" : "R4 delayed on", tgt, pol ? on_exp : ~on_exp);
      // R5 R7: opposite output released at once and never overlaps
      check("R5 opposite off", oth, ~pol);
      if ((tgt == pol) && (oth == pol)) check("R7 overlap", 1'b1, 1'b0);
      dly_cnt = 7'((d + 5) % 128);          // R8: ignored mid-count
      tick    = (((j + 1) % p) == 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset with active-high polarity
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset up", drv_up, 1'b0);
    check("R1 reset dn", drv_dn, 1'b0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R2 low side requested at pwm=0, zero delay
    check("R2 dn after reset", drv_dn, 1'b1);
    check("R2 up after reset", drv_up, 1'b0);

    for (int pi = 0; pi < 2; pi++) begin
      for (int ti = 0; ti < 2; ti++) begin
        for (int d = 0; d < 10; d++) begin
          phase(1'b1, d, ti ? 3 : 1, pi ? 1'b0 : 1'b1);
          phase(1'b0, d, ti ? 3 : 1, pi ? 1'b0 : 1'b1);
        end
      end
    end
    phase(1'b1, 127, 1, 1'b1);
    phase(1'b0, 127, 1, 1'b1);

    // R6 cancel a pending activation
    @(negedge clk);
    pwm_in = 1'b1; dly_cnt = 7'd10; tick = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 up held off", drv_up, 1'b0);
    end
    phase(1'b0, 3, 1, 1'b1);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 up stays off", drv_up, 1'b0);
    end
    phase(1'b1, 2, 1, 1'b1);

    // R1 R10 reset with active-low polarity
    @(negedge clk);
    rst = 1'b1; act_high = 1'b0; pwm_in = 1'b0; dly_cnt = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset up low pol", drv_up, 1'b1);
    check("R1 reset dn low pol", drv_dn, 1'b1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 dn active low", drv_dn, 1'b0);
    check("R10 up inactive high", drv_up, 1'b1);
    finish_run();
  end
endmodule